// File: doc/BRIEF.md
# SPI Pause Gate

This block sits between the raw pins of an SPI target and its serial command engine. It lets the host pause a transfer and resume it later. It resynchronises chip select, serial clock, serial input and the pause request onto the system clock. It then gives the engine one-cycle strobes for the serial clock's rising and falling edges, a gated serial-input level and a select level. It also qualifies the engine's serial-output data and enable before they reach the pad.

While a pause is active, the engine receives no clock strobes and its serial input is frozen, so its state does not change. When the pause is released, the transfer continues from the bit where it stopped. Entering or leaving a pause needs the synchronised serial clock to be low. A pause request that changes while the clock is high takes effect only at the next falling edge. Pulling the pause request low disables the serial output without waiting for that qualification. Deselecting the device always ends the transaction and clears any pause.

Top module: `spi_pause_gate`

## Requirements
- R1: Each pin input passes through SYNC_STAGES (default 2) system-clock flops. A level change driven between clock edges shows on the combinational outputs after exactly SYNC_STAGES rising edges.
- R2: While selected and not paused, each rising serial-clock level change gives a one-cycle `sck_rise_o` pulse, and each falling one gives a one-cycle `sck_fall_o` pulse.
- R3: When `hold_n_i` is low while the synchronised serial clock is low, the pause begins. From the next cycle on, both strobes stay low while the serial clock toggles.
- R4: If `hold_n_i` goes low while the serial clock is high, clock activity still passes until the next falling edge. The pause begins at that falling edge, and that edge gives no `sck_fall_o` pulse.
- R5: A pause ends only when `hold_n_i` is high while the serial clock is low. If it rises while the clock is high, the pause ends at the next falling edge, and that edge gives no `sck_fall_o` pulse. The first strobe after a pause is a rising one.
- R6: `si_o` follows the synchronised serial input while selected and not paused. While paused or deselected, it holds the last value it passed.
- R7: `so_en_o` is 1 only when `eng_so_en_i` is 1, the device is selected, the synchronised `hold_n_i` is high and no pause is active. `hold_n_i` going low clears `so_en_o` after SYNC_STAGES edges, with no wait for the serial clock. `so_o` equals `eng_so_i` when enabled and is 0 otherwise.
- R8: While `cs_n_i` is high, `sel_o` is 0 and no strobes are issued. Raising `cs_n_i` clears a pending or active pause, so the next selection starts unpaused, whatever the level of `hold_n_i` and the clock.
- R9: During reset, `sel_o`, both strobes, `si_o`, `so_o` and `so_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select pin, low selects |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data input pin |
| hold_n_i | input | 1 | Pause request pin, low pauses |
| eng_so_i | input | 1 | Serial output data from the engine |
| eng_so_en_i | input | 1 | Serial output enable from the engine |
| sel_o | output | 1 | Synchronised select level for the engine |
| sck_rise_o | output | 1 | Gated one-cycle rising-edge strobe |
| sck_fall_o | output | 1 | Gated one-cycle falling-edge strobe |
| si_o | output | 1 | Gated serial input level |
| so_o | output | 1 | Qualified serial output data |
| so_en_o | output | 1 | Final serial output enable |

## Verification
Every combinational result appears SYNC_STAGES rising edges after a pin change, and the pause state register lags by one more edge. Edge strobes last exactly one cycle. Table rows therefore hold each pin pattern for four cycles and check levels at the end of the row. Strobes are counted per row by a monitor on the falling clock edge, so a strobe that appears anywhere inside the row is counted. Directed tests check the exact edge where a strobe rises and the exact edge where the enable drops after `hold_n_i` falls, sampling two time units after each rising edge.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;

  typedef struct packed {
    logic cs_n;
    logic hold_n;
    logic sck;
    logic si;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);

  localparam pin_t PIN_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0, si: 1'b0};

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } pause_st_e;

endpackage

// File: rtl/spi_pause_sync.sv
module spi_pause_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_pause_edge.sv
module spi_pause_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);

  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;

endmodule

// File: rtl/spi_pause_ctl.sv
module spi_pause_ctl
  import spi_pause_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic hold_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic eng_so_i,
  input  logic eng_so_en_i,
  output logic rise_o,
  output logic fall_o,
  output logic si_o,
  output logic so_o,
  output logic so_en_o,
  output logic halt_o
);

  pause_st_e st_q, st_d;
  logic      enter;
  logic      blocked;
  logic      si_hold_q;

  // transitions are qualified by a low serial clock level
  always_comb begin
    st_d = st_q;
    if (!sel_i) begin
      st_d = ST_RUN;
    end else if (!sck_i) begin
      if (st_q == ST_RUN && !hold_n_i)      st_d = ST_HALT;
      else if (st_q == ST_HALT && hold_n_i) st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  // edges at both pause boundaries belong to the pause
  assign enter   = (st_q == ST_RUN) && (st_d == ST_HALT);
  assign blocked = (st_q == ST_HALT) || enter || !sel_i;

  assign rise_o = rise_i & ~blocked;
  assign fall_o = fall_i & ~blocked;
  assign si_o   = blocked ? si_hold_q : si_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) si_hold_q <= 1'b0;
    else         si_hold_q <= si_o;
  end

  assign so_en_o = eng_so_en_i & sel_i & hold_n_i & (st_q == ST_RUN);
  assign so_o    = eng_so_i & so_en_o;
  assign halt_o  = (st_q == ST_HALT);

endmodule

// File: rtl/spi_pause_gate.sv
module spi_pause_gate
  import spi_pause_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_n_i,
  input  logic eng_so_i,
  input  logic eng_so_en_i,
  output logic sel_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic si_o,
  output logic so_o,
  output logic so_en_o
);

  pin_t pin_raw, pin_s;
  logic sck_rise, sck_fall;
  logic halt;
  logic hold_s, sck_s;

  assign pin_raw = '{cs_n: cs_n_i, hold_n: hold_n_i, sck: sck_i, si: si_i};

  spi_pause_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  assign hold_s = pin_s.hold_n;
  assign sck_s  = pin_s.sck;
  assign sel_o  = ~pin_s.cs_n;

  spi_pause_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_s),
    .rise_o(sck_rise),
    .fall_o(sck_fall)
  );

  spi_pause_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_o),
    .hold_n_i   (hold_s),
    .sck_i      (sck_s),
    .si_i       (pin_s.si),
    .rise_i     (sck_rise),
    .fall_i     (sck_fall),
    .eng_so_i   (eng_so_i),
    .eng_so_en_i(eng_so_en_i),
    .rise_o     (sck_rise_o),
    .fall_o     (sck_fall_o),
    .si_o       (si_o),
    .so_o       (so_o),
    .so_en_o    (so_en_o),
    .halt_o     (halt)
  );

endmodule

// File: rtl/spi_pause_gate_chk.sv
module spi_pause_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic rise_i,
  input logic fall_i,
  input logic si_i,
  input logic so_en_i,
  input logic halt_i,
  input logic hold_s_i,
  input logic sck_s_i
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_i, fall_i}));

  // R2
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !rise_i);

  // R3
  halt_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> (!rise_i && !fall_i));

  // R3
  halt_entry_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_i) |-> $past(!sck_s_i));

  // R5
  halt_exit_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_i) |-> ($past(!sck_s_i) || $past(!sel_i)));

  // R6
  si_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && $past(halt_i)) |-> $stable(si_i));

  // R7
  hold_tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_s_i |-> !so_en_i);

  // R8
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (!rise_i && !fall_i && !so_en_i));

  // R8
  desel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !halt_i);

endmodule

bind spi_pause_gate spi_pause_gate_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_o),
  .rise_i  (sck_rise_o),
  .fall_i  (sck_fall_o),
  .si_i    (si_o),
  .so_en_i (so_en_o),
  .halt_i  (halt),
  .hold_s_i(hold_s),
  .sck_s_i (sck_s)
);

// File: tb/test_spi_pause_gate.sv
module test_spi_pause_gate;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic cs_n_i, sck_i, si_i, hold_n_i, eng_so_i, eng_so_en_i;
  logic sel_o, sck_rise_o, sck_fall_o, si_o, so_o, so_en_o;

  int n_chk = 0;
  int n_bad = 0;
  int r_cnt = 0;
  int f_cnt = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  spi_pause_gate i_spi_pause_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .sck_i      (sck_i),
    .si_i       (si_i),
    .hold_n_i   (hold_n_i),
    .eng_so_i   (eng_so_i),
    .eng_so_en_i(eng_so_en_i),
    .sel_o      (sel_o),
    .sck_rise_o (sck_rise_o),
    .sck_fall_o (sck_fall_o),
    .si_o       (si_o),
    .so_o       (so_o),
    .so_en_o    (so_en_o)
  );

  always @(negedge clk_i) begin
    if (sck_rise_o) r_cnt++;
    if (sck_fall_o) f_cnt++;
  end

  // row: {cs_n, hold_n, sck, si, exp so_en, exp si_o, exp rises, exp falls}
  localparam int NROW = 19;
  localparam logic [7:0] VEC [NROW] = '{
    8'b1100_0000, 8'b0101_1100, 8'b0111_1110, 8'b0100_1001,
    8'b0000_0000, 8'b0011_0000, 8'b0001_0000, 8'b0101_1100,
    8'b0111_1110, 8'b0010_0000, 8'b0000_0000, 8'b0111_0000,
    8'b0101_1100, 8'b0111_1110, 8'b0001_0100, 8'b1001_0100,
    8'b1111_0100, 8'b0111_1100, 8'b0101_1101
  };

  function automatic string row_req(int i);
    case (i)
      0, 15, 16, 17, 18: return "R8";
      1, 6:              return "R6";
      2, 3, 13:          return "R2";
      4, 5:              return "R3";
      9, 10, 14:         return "R4";
      default:           return "R5";
    endcase
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    cs_n_i = 1'b1; hold_n_i = 1'b1; sck_i = 1'b0; si_i = 1'b0;
    eng_so_i = 1'b1; eng_so_en_i = 1'b1;
    tick(); tick();
    // R9 reset state
    chk(sel_o == 1'b0, "R9", "sel_o", sel_o, 0);
    chk({sck_rise_o, sck_fall_o} == 2'b00, "R9", "strobes", {sck_rise_o, sck_fall_o}, 0);
    chk(si_o == 1'b0, "R9", "si_o", si_o, 0);
    chk({so_o, so_en_o} == 2'b00, "R9", "so", {so_o, so_en_o}, 0);
    rst_ni = 1'b1;
    tick(); tick();

    for (int i = 0; i < NROW; i++) begin
      int r0, f0;
      r0 = r_cnt; f0 = f_cnt;
      cs_n_i = VEC[i][7]; hold_n_i = VEC[i][6]; sck_i = VEC[i][5]; si_i = VEC[i][4];
      for (int k = 0; k < 4; k++) tick();
      chk(so_en_o == VEC[i][3], row_req(i), $sformatf("row %0d so_en_o", i), so_en_o, VEC[i][3]);
      chk(si_o == VEC[i][2], row_req(i), $sformatf("row %0d si_o", i), si_o, VEC[i][2]);
      chk((r_cnt - r0) == int'(VEC[i][1]), row_req(i), $sformatf("row %0d rises", i),
          r_cnt - r0, VEC[i][1]);
      chk((f_cnt - f0) == int'(VEC[i][0]), row_req(i), $sformatf("row %0d falls", i),
          f_cnt - f0, VEC[i][0]);
    end

    // R1 latency of rising strobe: selected, unpaused, sck low
    sck_i = 1'b1;
    tick();
    chk(sck_rise_o == 1'b0, "R1", "rise after 1 edge", sck_rise_o, 0);
    tick();
    chk(sck_rise_o == 1'b1, "R1", "rise after 2 edges", sck_rise_o, 1);
    tick();
    chk(sck_rise_o == 1'b0, "R2", "rise width one cycle", sck_rise_o, 0);
    tick();

    // R7 hold low drops enable after two edges with sck high
    chk(so_en_o == 1'b1, "R7", "so_en before hold", so_en_o, 1);
    hold_n_i = 1'b0;
    tick();
    chk(so_en_o == 1'b1, "R7", "so_en after 1 edge", so_en_o, 1);
    tick();
    chk(so_en_o == 1'b0, "R7", "so_en after 2 edges", so_en_o, 0);
    hold_n_i = 1'b1;
    for (int k = 0; k < 4; k++) tick();

    // R7 data qualification
    eng_so_i = 1'b0;
    #1;
    chk(so_o == 1'b0, "R7", "so_o data 0", so_o, 0);
    eng_so_i = 1'b1;
    #1;
    chk(so_o == 1'b1, "R7", "so_o data 1", so_o, 1);
    eng_so_en_i = 1'b0;
    #1;
    chk(so_en_o == 1'b0, "R7", "so_en engine off", so_en_o, 0);
    chk(so_o == 1'b0, "R7", "so_o engine off", so_o, 0);

    finish_run();
  end

endmodule